// File: doc/BRIEF.md
# Dual-Clock Scanning ADC Controller

This block is the digital half of a successive-approximation converter that sits across two clocks. On the system clock it keeps a small register file that software writes. Channel enables, a compare threshold and the compare options are edited in a working copy. That copy reaches the converter clock only when software issues an update command. The system side also samples two of the four start inputs, collects the conversion results and keeps two sticky interrupt flags: scan finished, and compare hit.

On the converter clock the block scans the enabled inputs of an eight-way analog multiplexer in rising index order. For each input it spends one cycle sampling and then one cycle per result bit, taking the converter's serial output MSB first. Each result, its channel and its compare verdict are held and handed to the system side through a toggle request and acknowledge. The converter-clock side holds off the next conversion until the system side has taken the result. That acknowledge is the only back-pressure point, and the result stream cannot drop a value. The converter clock must not be faster than the system clock.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset every readable register reads zero, both interrupt outputs are low, and `conv_sample` and `conv_busy` are low.
- R2: Writes to the channel-enable (address 0), threshold (address 1) and compare-option (address 2) registers change only the working copy. A scan uses the settings copied at the most recent update command, which is a write of 1 in bit 0 of address 3.
- R3: Address 5 bit 0 reads 1 from the update command until the converter-clock side has taken the copied settings, then 0. An update command given while that bit is 1 is ignored, and the earlier copy stays in force.
- R4: A rising edge on `start_a_i` or `start_c_i` (system clock) or on `start_b_i` or `start_d_i` (converter clock) starts a scan when no scan is running and at least one channel is enabled.
- R5: A start edge that arrives while a scan is running is ignored and does not cause a further scan.
- R6: A scan samples each enabled channel once, in ascending index order, and drives `mux_sel` with that index. Each conversion raises `conv_sample` for one cycle and then takes RES bits from `conv_bit`, MSB first. `conv_busy` is high for exactly RES+1 converter cycles per conversion.
- R7: Result register at address 8+i reads the latest value of channel i in bits [RES-1:0] and a valid flag in bit 15. The flag is set when a result lands and cleared by any write to that address.
- R8: When the last result of a scan has been written, interrupt flag bit 0 (address 4) is set and `irq_scan_done` goes high.
- R9: A result of a channel whose bit is set in address 2 bits [7:0] is a compare hit when it is strictly above the threshold with address 2 bit 8 at 1, or strictly below it with bit 8 at 0. A hit sets interrupt flag bit 1 and `irq_compare`. A value equal to the threshold is no hit.
- R10: Interrupt flags stay set until a 1 is written to their bit at address 4. Writing 0 to a bit leaves it unchanged.
- R11: The next conversion does not begin before the system side has acknowledged the previous result, and the held result does not change while it waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Active-low reset, system side |
| adc_clk | input | 1 | Converter clock, no faster than sys_clk |
| adc_rst_n | input | 1 | Active-low reset, converter side |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| start_a_i | input | 1 | Start trigger sampled on sys_clk |
| start_c_i | input | 1 | Start trigger sampled on sys_clk |
| start_b_i | input | 1 | Start trigger sampled on adc_clk |
| start_d_i | input | 1 | Start trigger sampled on adc_clk |
| conv_bit | input | 1 | Serial result bit from the converter |
| mux_sel | output | 3 | Analog multiplexer select |
| conv_sample | output | 1 | Sample phase of a conversion |
| conv_busy | output | 1 | Conversion in progress |
| irq_scan_done | output | 1 | Sticky scan-finished interrupt |
| irq_compare | output | 1 | Sticky compare-hit interrupt |

## Verification
The hardest case to reach is a second update command landing while the first is still crossing to the converter clock. The window lasts only a few converter cycles. The bench issues the command, rewrites the working copy and repeats the command on consecutive system cycles, so the second one always falls inside the window. The scan that follows shows which copy took effect. A start edge during a running scan is reached by waiting a fixed number of converter cycles after the first start and then pulsing triggers from both clock domains.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int REG_W = 16;
  localparam int A_CHAN_EN = 0;
  localparam int A_THRESH  = 1;
  localparam int A_CMP_OPT = 2;
  localparam int A_CMD     = 3;
  localparam int A_IRQ     = 4;
  localparam int A_STATUS  = 5;

  typedef enum logic [1:0] {
    SC_IDLE,
    SC_SAMPLE,
    SC_CONV,
    SC_HAND
  } scan_st_e;
endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/adc_seq_sys.sv
module adc_seq_sys
  import adc_seq_pkg::*;
#(
  parameter int NCH = 8,
  parameter int RES = 10,
  parameter int AW  = 4,
  parameter int CHW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [REG_W-1:0] rd_data,
  input  logic             start_a,
  input  logic             start_c,
  output logic             start_tgl,
  output logic             upd_tgl,
  output logic [NCH-1:0]   xfer_en,
  output logic [RES-1:0]   xfer_thr,
  output logic [NCH-1:0]   xfer_cmpen,
  output logic             xfer_dir,
  input  logic             upd_ack_s,
  input  logic             res_tgl_s,
  input  logic [CHW-1:0]   res_ch,
  input  logic [RES-1:0]   res_data,
  input  logic             res_hit,
  input  logic             done_tgl_s,
  output logic             res_ack_tgl,
  output logic             irq_done,
  output logic             irq_cmp
);
  logic [NCH-1:0]     sh_en;
  logic [RES-1:0]     sh_thr;
  logic [NCH-1:0]     sh_cmpen;
  logic               sh_dir;
  logic [1:0]         st_prev;
  logic               res_seen;
  logic               done_seen;
  logic               pending;
  logic               res_new;
  logic               done_new;
  logic               wr_irq;
  logic               clr_done;
  logic               clr_cmp;
  logic [NCH*RES-1:0] res_val_flat;
  logic [NCH-1:0]     res_vld;

  assign pending  = upd_tgl ^ upd_ack_s;
  assign res_new  = res_tgl_s ^ res_seen;
  assign done_new = done_tgl_s ^ done_seen;
  assign wr_irq   = wr_en && (wr_addr == AW'(A_IRQ));
  assign clr_done = wr_irq && wr_data[0];
  assign clr_cmp  = wr_irq && wr_data[1];
  assign res_ack_tgl = res_seen;

  // working copy of the configuration
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_en    <= '0;
      sh_thr   <= '0;
      sh_cmpen <= '0;
      sh_dir   <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == AW'(A_CHAN_EN)) sh_en  <= wr_data[NCH-1:0];
      if (wr_addr == AW'(A_THRESH))  sh_thr <= wr_data[RES-1:0];
      if (wr_addr == AW'(A_CMP_OPT)) begin
        sh_cmpen <= wr_data[NCH-1:0];
        sh_dir   <= wr_data[NCH];
      end
    end
  end

  // update request: snapshot held stable until acknowledged
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_en    <= '0;
      xfer_thr   <= '0;
      xfer_cmpen <= '0;
      xfer_dir   <= 1'b0;
      upd_tgl    <= 1'b0;
    end else if (wr_en && wr_addr == AW'(A_CMD) && wr_data[0] && !pending) begin
      xfer_en    <= sh_en;
      xfer_thr   <= sh_thr;
      xfer_cmpen <= sh_cmpen;
      xfer_dir   <= sh_dir;
      upd_tgl    <= ~upd_tgl;
    end
  end

  // system-clock start triggers become a toggle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_prev   <= '0;
      start_tgl <= 1'b0;
    end else begin
      st_prev <= {start_c, start_a};
      if ((start_a && !st_prev[0]) || (start_c && !st_prev[1]))
        start_tgl <= ~start_tgl;
    end
  end

  // result and done toggles, sticky flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_seen  <= 1'b0;
      done_seen <= 1'b0;
      irq_done  <= 1'b0;
      irq_cmp   <= 1'b0;
    end else begin
      res_seen  <= res_tgl_s;
      done_seen <= done_tgl_s;
      irq_done  <= (irq_done && !clr_done) || done_new;
      irq_cmp   <= (irq_cmp && !clr_cmp) || (res_new && res_hit);
    end
  end

  for (genvar gi = 0; gi < NCH; gi++) begin : g_res
    logic [RES-1:0] val;
    logic           vld;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val <= '0;
        vld <= 1'b0;
      end else if (res_new && res_ch == CHW'(gi)) begin
        val <= res_data;
        vld <= 1'b1;
      end else if (wr_en && wr_addr == AW'(NCH + gi)) begin
        vld <= 1'b0;
      end
    end
    assign res_val_flat[gi*RES +: RES] = val;
    assign res_vld[gi] = vld;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == AW'(A_CHAN_EN)) rd_data[NCH-1:0] = sh_en;
    if (rd_addr == AW'(A_THRESH))  rd_data[RES-1:0] = sh_thr;
    if (rd_addr == AW'(A_CMP_OPT)) rd_data[NCH:0]   = {sh_dir, sh_cmpen};
    if (rd_addr == AW'(A_IRQ))     rd_data[1:0]     = {irq_cmp, irq_done};
    if (rd_addr == AW'(A_STATUS))  rd_data[0]       = pending;
    for (int i = 0; i < NCH; i++) begin
      if (rd_addr == AW'(NCH + i)) begin
        rd_data[REG_W-1]  = res_vld[i];
        rd_data[RES-1:0]  = res_val_flat[i*RES +: RES];
      end
    end
  end

  AST_XFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && $past(pending)) |-> ($stable(xfer_en) && $stable(xfer_thr))); // R3
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_done) && !$past(clr_done)) |-> irq_done); // R10
  AST_CMP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_cmp) && !$past(clr_cmp)) |-> irq_cmp); // R10
endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core
  import adc_seq_pkg::*;
#(
  parameter int NCH = 8,
  parameter int RES = 10,
  parameter int CHW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_tgl_s,
  input  logic           start_b,
  input  logic           start_d,
  input  logic           upd_tgl_s,
  input  logic [NCH-1:0] xfer_en,
  input  logic [RES-1:0] xfer_thr,
  input  logic [NCH-1:0] xfer_cmpen,
  input  logic           xfer_dir,
  input  logic           res_ack_s,
  input  logic           conv_bit,
  output logic           upd_ack_tgl,
  output logic           res_tgl,
  output logic [CHW-1:0] res_ch,
  output logic [RES-1:0] res_data,
  output logic           res_hit,
  output logic           done_tgl,
  output logic [CHW-1:0] mux_sel,
  output logic           conv_sample,
  output logic           conv_busy
);
  localparam int CW = (RES > 1) ? $clog2(RES) : 1;

  scan_st_e       state;
  logic [NCH-1:0] act_en;
  logic [RES-1:0] act_thr;
  logic [NCH-1:0] act_cmpen;
  logic           act_dir;
  logic           upd_seen;
  logic           start_seen;
  logic [1:0]     st_prev;
  logic [CHW-1:0] ch;
  logic [CW-1:0]  cnt;
  logic [RES-1:0] shreg;
  logic           upd_take;
  logic           start_hit;
  logic [NCH-1:0] eff_en;
  logic [CHW:0]   first_ch;
  logic [CHW:0]   next_ch;
  logic [RES-1:0] full;
  logic           hit_now;

  function automatic logic [CHW:0] find_from(input logic [NCH-1:0] m, input int lo);
    logic [CHW:0] r;
    r = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (m[i] && i >= lo) r = {1'b1, CHW'(i)};
    end
    return r;
  endfunction

  assign upd_take  = (state == SC_IDLE) && (upd_tgl_s != upd_seen);
  assign start_hit = (start_tgl_s != start_seen) || (start_b && !st_prev[0]) ||
                     (start_d && !st_prev[1]);
  assign eff_en    = upd_take ? xfer_en : act_en;
  assign first_ch  = find_from(eff_en, 0);
  assign next_ch   = find_from(act_en, int'(ch) + 1);
  assign full      = {shreg[RES-2:0], conv_bit};
  assign hit_now   = act_cmpen[ch] && (act_dir ? (full > act_thr) : (full < act_thr));

  assign upd_ack_tgl = upd_seen;
  assign mux_sel     = ch;
  assign conv_sample = (state == SC_SAMPLE);
  assign conv_busy   = (state == SC_SAMPLE) || (state == SC_CONV);

  // active configuration: applied only between scans
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_en    <= '0;
      act_thr   <= '0;
      act_cmpen <= '0;
      act_dir   <= 1'b0;
      upd_seen  <= 1'b0;
    end else if (upd_take) begin
      act_en    <= xfer_en;
      act_thr   <= xfer_thr;
      act_cmpen <= xfer_cmpen;
      act_dir   <= xfer_dir;
      upd_seen  <= upd_tgl_s;
    end
  end

  // scan sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SC_IDLE;
      start_seen <= 1'b0;
      st_prev    <= '0;
      ch         <= '0;
      cnt        <= '0;
      shreg      <= '0;
      res_tgl    <= 1'b0;
      res_ch     <= '0;
      res_data   <= '0;
      res_hit    <= 1'b0;
      done_tgl   <= 1'b0;
    end else begin
      start_seen <= start_tgl_s;
      st_prev    <= {start_d, start_b};
      unique case (state)
        SC_IDLE: begin
          if (start_hit && first_ch[CHW]) begin
            ch    <= first_ch[CHW-1:0];
            state <= SC_SAMPLE;
          end
        end
        SC_SAMPLE: begin
          cnt   <= '0;
          state <= SC_CONV;
        end
        SC_CONV: begin
          shreg <= full;
          cnt   <= cnt + 1'b1;
          if (cnt == CW'(RES - 1)) begin
            res_data <= full;
            res_ch   <= ch;
            res_hit  <= hit_now;
            res_tgl  <= ~res_tgl;
            state    <= SC_HAND;
          end
        end
        SC_HAND: begin
          if (res_ack_s == res_tgl) begin
            if (next_ch[CHW]) begin
              ch    <= next_ch[CHW-1:0];
              state <= SC_SAMPLE;
            end else begin
              done_tgl <= ~done_tgl;
              state    <= SC_IDLE;
            end
          end
        end
        default: state <= SC_IDLE;
      endcase
    end
  end

  AST_SAMPLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_sample |=> !conv_sample); // R6
  AST_SEL_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    conv_sample |-> act_en[mux_sel]); // R6
  AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SC_CONV) |-> $stable(mux_sel)); // R6
  AST_PAYLOAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SC_HAND && $past(state) == SC_HAND) |-> ($stable(res_data) && $stable(res_tgl))); // R11
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NCH = 8,
  parameter int RES = 10,
  localparam int AW  = $clog2(NCH) + 1,
  localparam int CHW = $clog2(NCH)
) (
  input  logic             sys_clk,
  input  logic             sys_rst_n,
  input  logic             adc_clk,
  input  logic             adc_rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [REG_W-1:0] rd_data,
  input  logic             start_a_i,
  input  logic             start_c_i,
  input  logic             start_b_i,
  input  logic             start_d_i,
  input  logic             conv_bit,
  output logic [CHW-1:0]   mux_sel,
  output logic             conv_sample,
  output logic             conv_busy,
  output logic             irq_scan_done,
  output logic             irq_compare
);
  logic           start_tgl, upd_tgl, res_ack_tgl;
  logic           upd_ack_tgl, res_tgl, done_tgl;
  logic [2:0]     to_adc_s, to_sys_s;
  logic [NCH-1:0] xfer_en, xfer_cmpen;
  logic [RES-1:0] xfer_thr;
  logic           xfer_dir;
  logic [CHW-1:0] res_ch;
  logic [RES-1:0] res_data;
  logic           res_hit;

  adc_seq_sys #(.NCH(NCH), .RES(RES), .AW(AW), .CHW(CHW)) sys_i (
    .clk(sys_clk), .rst_n(sys_rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .start_a(start_a_i), .start_c(start_c_i), .start_tgl(start_tgl),
    .upd_tgl(upd_tgl), .xfer_en(xfer_en), .xfer_thr(xfer_thr),
    .xfer_cmpen(xfer_cmpen), .xfer_dir(xfer_dir),
    .upd_ack_s(to_sys_s[0]), .res_tgl_s(to_sys_s[1]),
    .res_ch(res_ch), .res_data(res_data), .res_hit(res_hit),
    .done_tgl_s(to_sys_s[2]), .res_ack_tgl(res_ack_tgl),
    .irq_done(irq_scan_done), .irq_cmp(irq_compare)
  );

  adc_seq_sync #(.W(3)) sync_to_adc_i (
    .clk(adc_clk), .rst_n(adc_rst_n),
    .d({res_ack_tgl, upd_tgl, start_tgl}), .q(to_adc_s)
  );

  adc_seq_sync #(.W(3)) sync_to_sys_i (
    .clk(sys_clk), .rst_n(sys_rst_n),
    .d({done_tgl, res_tgl, upd_ack_tgl}), .q(to_sys_s)
  );

  adc_seq_core #(.NCH(NCH), .RES(RES), .CHW(CHW)) core_i (
    .clk(adc_clk), .rst_n(adc_rst_n),
    .start_tgl_s(to_adc_s[0]), .start_b(start_b_i), .start_d(start_d_i),
    .upd_tgl_s(to_adc_s[1]), .xfer_en(xfer_en), .xfer_thr(xfer_thr),
    .xfer_cmpen(xfer_cmpen), .xfer_dir(xfer_dir),
    .res_ack_s(to_adc_s[2]), .conv_bit(conv_bit),
    .upd_ack_tgl(upd_ack_tgl), .res_tgl(res_tgl), .res_ch(res_ch),
    .res_data(res_data), .res_hit(res_hit), .done_tgl(done_tgl),
    .mux_sel(mux_sel), .conv_sample(conv_sample), .conv_busy(conv_busy)
  );
endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;
  localparam int NCH = 8;
  localparam int RES = 10;

  logic        sys_clk = 0, adc_clk = 0;
  logic        sys_rst_n = 0, adc_rst_n = 0;
  logic        wr_en = 0;
  logic [3:0]  wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0, rd_data;
  logic        start_a = 0, start_b = 0, start_c = 0, start_d = 0;
  logic        conv_bit;
  logic [2:0]  mux_sel;
  logic        conv_sample, conv_busy, irq_scan_done, irq_compare;

  int checks = 0, errors = 0;
  int ord [16];
  int nsamp = 0;
  int busy_len = 0;
  logic [RES-1:0] sr = '0;

  always #2 sys_clk = ~sys_clk;
  always #6 adc_clk = ~adc_clk;

  adc_seq_ctrl #(.NCH(NCH), .RES(RES)) dut_i (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .adc_clk(adc_clk), .adc_rst_n(adc_rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .start_a_i(start_a), .start_c_i(start_c), .start_b_i(start_b), .start_d_i(start_d),
    .conv_bit(conv_bit), .mux_sel(mux_sel), .conv_sample(conv_sample),
    .conv_busy(conv_busy), .irq_scan_done(irq_scan_done), .irq_compare(irq_compare)
  );

  function automatic int chan_val(input int i);
    return (i * 131 + 53) % 1024;
  endfunction

  // converter model: loads on sample, shifts out MSB first
  always @(posedge adc_clk) begin
    if (conv_sample) sr <= RES'(chan_val(int'(mux_sel)));
    else             sr <= sr << 1;
  end
  assign conv_bit = sr[RES-1];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor on the falling converter edge
  always @(negedge adc_clk) begin
    if (conv_sample) begin
      if (nsamp < 16) ord[nsamp] = int'(mux_sel);
      nsamp++;
    end
    if (conv_busy) busy_len++;
    else if (busy_len != 0) begin
      chk("R6 conv_busy length", busy_len, RES + 1);
      busy_len = 0;
    end
  end

  task automatic wr(input int a, input int d);
    wr_en = 1; wr_addr = 4'(a); wr_data = 16'(d);
    @(negedge sys_clk);
    wr_en = 0;
  endtask

  task automatic rd(input int a, output int d);
    rd_addr = 4'(a);
    #1;
    d = int'(rd_data);
  endtask

  task automatic wait_upd();
    int d;
    rd(5, d);
    while (d[0]) begin
      @(negedge sys_clk);
      rd(5, d);
    end
  endtask

  task automatic do_update(input int en, input int thr, input int opt);
    wr(0, en); wr(1, thr); wr(2, opt); wr(3, 1);
    wait_upd();
  endtask

  task automatic pulse_start(input int sel);
    case (sel)
      0: begin start_a = 1; @(negedge sys_clk); start_a = 0; end
      2: begin start_c = 1; @(negedge sys_clk); start_c = 0; end
      1: begin @(negedge adc_clk); start_b = 1; @(negedge adc_clk); start_b = 0; end
      default: begin @(negedge adc_clk); start_d = 1; @(negedge adc_clk); start_d = 0; end
    endcase
    @(negedge sys_clk);
  endtask

  task automatic scan(input int sel);
    nsamp = 0;
    pulse_start(sel);
    while (!irq_scan_done) @(negedge sys_clk);
    repeat (4) @(negedge adc_clk);
    @(negedge sys_clk);
  endtask

  task automatic clear_all();
    wr(4, 3);
    for (int i = 0; i < NCH; i++) wr(8 + i, 0);
  endtask

  // en[28:21] thr[20:11] cmpen[10:3] dir[2] start[1:0]
  localparam logic [28:0] VEC [0:4] = '{
    {8'hFF, 10'd500, 8'hFF, 1'b1, 2'd0},
    {8'hA5, 10'd100, 8'h01, 1'b0, 2'd1},
    {8'h18, 10'd900, 8'h18, 1'b1, 2'd2},
    {8'h80, 10'd969, 8'h80, 1'b1, 2'd3},
    {8'h80, 10'd970, 8'h80, 1'b1, 2'd0}
  };

  initial begin
    repeat (180000) @(posedge sys_clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int d;
    repeat (4) @(negedge adc_clk);
    sys_rst_n = 1; adc_rst_n = 1;
    @(negedge sys_clk);

    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      rd(a, d);
      chk($sformatf("R1 reg %0d after reset", a), d, 0);
    end
    chk("R1 irq_scan_done", int'(irq_scan_done), 0);
    chk("R1 irq_compare", int'(irq_compare), 0);
    chk("R1 conv_busy", int'(conv_busy), 0);
    chk("R1 conv_sample", int'(conv_sample), 0);

    // vector table walk: R4 R6 R7 R8 R9 R10 R11
    for (int v = 0; v < 5; v++) begin
      int en, thr, cmpen, dir, sel, k, exp_hit;
      en = int'(VEC[v][28:21]); thr = int'(VEC[v][20:11]);
      cmpen = int'(VEC[v][10:3]); dir = int'(VEC[v][2]); sel = int'(VEC[v][1:0]);
      do_update(en, thr, cmpen | (dir << 8));
      scan(sel);
      k = 0; exp_hit = 0;
      for (int c = 0; c < NCH; c++) begin
        if (en[c]) begin
          if (k < 16) chk($sformatf("R6 order v%0d pos%0d", v, k), ord[k], c);
          k++;
          if (cmpen[c] && ((dir == 1 && chan_val(c) > thr) || (dir == 0 && chan_val(c) < thr)))
            exp_hit = 1;
        end
        rd(8 + c, d);
        // R7 and R11: every enabled result arrives intact
        chk($sformatf("R7 valid v%0d ch%0d", v, c), d >> 15, en[c] ? 1 : 0);
        if (en[c]) chk($sformatf("R7 R11 value v%0d ch%0d", v, c), d & 16'h3FF, chan_val(c));
      end
      chk($sformatf("R4 R6 sample count v%0d", v), nsamp, k);
      rd(4, d);
      chk($sformatf("R8 done flag v%0d", v), d & 1, 1);
      chk($sformatf("R9 compare flag v%0d", v), (d >> 1) & 1, exp_hit);
      chk($sformatf("R9 irq_compare pin v%0d", v), int'(irq_compare), exp_hit);
      wr(4, 1);
      rd(4, d);
      chk($sformatf("R10 clear only done v%0d", v), d, exp_hit << 1);
      wr(4, 0);
      rd(4, d);
      chk($sformatf("R10 write zero no effect v%0d", v), d, exp_hit << 1);
      wr(4, 2);
      chk($sformatf("R10 irq_scan_done low v%0d", v), int'(irq_scan_done), 0);
      clear_all();
      rd(8 + 7, d);
      chk($sformatf("R7 write clears valid v%0d", v), d >> 15, 0);
    end

    // R3: second update command while the first is pending is ignored
    wr(0, 1); wr(3, 1); wr(0, 2); wr(3, 1);
    rd(5, d);
    chk("R3 pending after command", d & 1, 1);
    wait_upd();
    repeat (30) @(negedge sys_clk);
    rd(5, d);
    chk("R3 pending stays clear", d & 1, 0);
    scan(0);
    chk("R3 one channel scanned", nsamp, 1);
    chk("R3 first copy in force", ord[0], 0);
    clear_all();

    // R2: working copy without update has no effect
    wr(0, 4);
    scan(2);
    chk("R2 old channel without update", ord[0], 0);
    chk("R2 sample count", nsamp, 1);
    clear_all();
    wr(3, 1);
    wait_upd();
    scan(1);
    chk("R2 new channel after update", ord[0], 2);
    clear_all();

    // R5: starts during a running scan are ignored
    do_update(8'hFF, 0, 0);
    nsamp = 0;
    pulse_start(0);
    repeat (20) @(negedge adc_clk);
    chk("R5 scan running", nsamp > 0 && nsamp < 8 ? 1 : 0, 1);
    pulse_start(1);
    pulse_start(2);
    pulse_start(3);
    while (!irq_scan_done) @(negedge sys_clk);
    repeat (200) @(negedge sys_clk);
    chk("R5 no extra scan", nsamp, 8);
    chk("R5 conv_busy idle", int'(conv_busy), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule